// File: doc/BRIEF.md
# Flow-Through Burst Synchronous Static Memory

This block is a synthesizable model of a synchronous static memory, 32 bits wide and 2**ADDR_W words deep. With ADDR_W = 15 it is the full 32768-word array. The default is ADDR_W = 10, which keeps elaboration small. Address, strobes, selects, write controls and write data are all taken on the rising clock edge. The read path has no output register: the word at the current access address reaches `rdata` combinationally in the cycle that follows the edge that set that address.

An access starts when either of two address strobes loads an address. One strobe comes from the processor side and the other from the cache-controller side. The start address is beat 0 of a four-beat burst. Each later edge with `advance_n` low steps a two-bit beat counter. The `order_sel` pin chooses whether the beat counter is added to the low two address bits (linear order) or XORed with them (interleaved order). Writes happen on the same edge that sets their address. They are gated for the whole word or per 8-bit lane.

Output enable and sleep act without a clock on the output flag. While sleep is high, the block freezes its access state and performs no writes.

Top module: `fts_sram`

## Requirements
- R1: While `rst` is high and after it, `rdata_vld` is 0 until an access is loaded. Reset clears the access state.
- R2: An edge with `ctl_strobe_n` low, or with both `proc_strobe_n` and `chip_en_n` low, is a start. A start while selected (`chip_en_n`=0, `sel_hi`=1, `sel_n`=0) loads `addr` as beat 0. In the following cycle `rdata` shows that word with `rdata_vld`=1 (when `out_en_n`=0).
- R3: A low `proc_strobe_n` with `chip_en_n` high is not a start, and the current access continues unchanged.
- R4: A start while not selected ends the access (`rdata_vld`=0, `rdata`=0). No write takes effect until the next selected start.
- R5: With `order_sel`=0 (linear), the low two address bits of beat k are (start+k) mod 4.
- R6: With `order_sel`=1 (interleaved), the low two address bits of beat k are start XOR k.
- R7: An edge with `advance_n` high and no start repeats the current address. After beat 3, an advance returns to beat 0.
- R8: With `all_wr_n` low, all four lanes are written, whatever `lane_wr_n` and `lane_sel_n` are.
- R9: With `all_wr_n` high and `lane_wr_n` low, lane i (`wdata[8i+7:8i]`) is written only when `lane_sel_n[i]` is 0.
- R10: With `all_wr_n` high and `lane_wr_n` high, or with `lane_wr_n` low and no lane selected, the cycle is a read and the memory is unchanged.
- R11: `out_en_n` high forces `rdata_vld`=0 and `rdata`=0 at once, with no clock edge.
- R12: While `sleep` is high, `rdata_vld` is 0, no write occurs and the access state does not change. When `sleep` falls, the old access reappears.
- R13: A start on an edge where `advance_n` is low loads the new address rather than advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Access start address |
| wdata | input | 32 | Write data, four 8-bit lanes |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, honoured only with chip enable |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Beat-advance request, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| sleep | input | 1 | Power-down, active high |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| rdata | output | 32 | Flow-through read data, 0 when not driven |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
The bench fills four words with a whole-word burst and reads them back in both orders from a start address that is not aligned. A sequencer that ignored the mode, or did not wrap inside the group of four, would return a neighbouring word. Lane writes with a mixed select pattern catch a swapped or inverted lane mask. Reads with the lane enable asserted but no lane selected catch a decoder that treats the enable alone as a write. Further cases cover a processor strobe with chip enable high, a deselecting start followed by a write attempt, a start combined with an advance, and sleep with a live write request. A design that obeyed the ignored strobe, kept writing after deselect, advanced instead of loading, or wrote or moved during sleep would show a wrong word on a later read.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic start;
        logic chosen;
        logic step;
    } seq_ev_t;

    function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] origin,
                                                    input logic [BEAT_W-1:0] beat,
                                                    input order_e ord);
        return (ord == ORD_LINEAR) ? origin + beat : origin ^ beat;
    endfunction

endpackage

// File: rtl/fts_seq.sv
module fts_seq
    import fts_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              ctl_strobe_n,
    input  logic              proc_strobe_n,
    input  logic              chip_en_n,
    input  logic              sel_hi,
    input  logic              sel_n,
    input  logic              advance_n,
    input  order_e            ord,
    input  logic [ADDR_W-1:0] addr,
    output logic              active_q,
    output logic              nxt_active,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] base_q, nxt_base;
    logic [BEAT_W-1:0] cnt_q, nxt_cnt;
    seq_ev_t           ev;

    always_comb begin
        ev.start  = !ctl_strobe_n || (!proc_strobe_n && !chip_en_n);
        ev.chosen = !chip_en_n && sel_hi && !sel_n;
        ev.step   = active_q && !advance_n;
    end

    always_comb begin
        nxt_active = active_q;
        nxt_base   = base_q;
        nxt_cnt    = cnt_q;
        if (!sleep) begin
            if (ev.start) begin
                nxt_active = ev.chosen;
                if (ev.chosen) begin
                    nxt_base = addr;
                    nxt_cnt  = '0;
                end
            end else if (ev.step) begin
                nxt_cnt = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            active_q <= nxt_active;
            base_q   <= nxt_base;
            cnt_q    <= nxt_cnt;
        end
    end

    assign cur_addr = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], cnt_q, ord)};
    assign nxt_addr = {nxt_base[ADDR_W-1:BEAT_W], beat_low(nxt_base[BEAT_W-1:0], nxt_cnt, ord)};

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ev.start && ev.chosen) |=> (active_q && cnt_q == '0 && base_q == $past(addr)));

    p_strobe_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ctl_strobe_n && chip_en_n) |=> ($stable(active_q) && $stable(base_q)));

    p_deselect_r4: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ev.start && !ev.chosen) |=> !active_q);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ev.start && advance_n) |=> ($stable(cnt_q) && $stable(base_q)));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ev.start && active_q && !advance_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

    p_sleep_freeze_r12: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(active_q) && $stable(base_q) && $stable(cnt_q)));

endmodule

// File: rtl/fts_wdec.sv
module fts_wdec #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = !all_wr_n || (!lane_wr_n && !lane_sel_n[i]);
    end

    always_comb begin
        if (all_wr_n && lane_wr_n) begin
            p_no_write_r10: assert (lane_we == '0);
        end
    end

endmodule

// File: rtl/fts_mem.sv
module fts_mem #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (we[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              proc_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              advance_n,
    input  logic              chip_en_n,
    input  logic              sel_hi,
    input  logic              sel_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic              order_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic              active_q, nxt_active;
    logic [ADDR_W-1:0] nxt_addr, cur_addr;
    logic [LANES-1:0]  lane_we, mem_we;
    logic [DATA_W-1:0] array_q;

    fts_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .sleep(sleep),
        .ctl_strobe_n(ctl_strobe_n), .proc_strobe_n(proc_strobe_n),
        .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_n(sel_n),
        .advance_n(advance_n), .ord(order_e'(order_sel)), .addr(addr),
        .active_q(active_q), .nxt_active(nxt_active),
        .nxt_addr(nxt_addr), .cur_addr(cur_addr)
    );

    fts_wdec #(.LANES(LANES)) u_wdec (
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .lane_we(lane_we)
    );

    assign mem_we = (nxt_active && !sleep && !rst) ? lane_we : '0;

    fts_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(nxt_addr), .wdata(wdata),
        .raddr(cur_addr), .rdata(array_q)
    );

    assign rdata_vld = active_q && !out_en_n && !sleep;
    assign rdata     = rdata_vld ? array_q : '0;

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (out_en_n || sleep) |-> (!rdata_vld && rdata == '0));

    p_sleep_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (mem_we == '0));

endmodule

// File: tb/tb_fts_sram.sv
module tb_fts_sram;

    typedef struct packed {
        logic [9:0]  a;
        logic        cs_n;     // controller strobe
        logic        ps_n;     // processor strobe
        logic        ce_n;
        logic        s_hi;
        logic        s_n;
        logic        adv_n;
        logic        aw_n;     // whole-word write
        logic        lw_n;     // lane-write enable
        logic [3:0]  ls_n;
        logic        ord;
        logic [31:0] d;
        logic        en;
        logic [31:0] q;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        // R2/R8: load 0x010, whole-word write
        '{10'h010,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,32'hA0A0A0A0,1'b1,32'hA0A0A0A0,8'd2},
        // R5: linear burst writes 0x011..0x013
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,32'hA1A1A1A1,1'b1,32'hA1A1A1A1,8'd5},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,32'hA2A2A2A2,1'b1,32'hA2A2A2A2,8'd5},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,32'hA3A3A3A3,1'b1,32'hA3A3A3A3,8'd5},
        // R7: advance past beat 3 wraps to start; R10 read ignores wdata
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,32'hFFFFFFFF,1'b1,32'hA0A0A0A0,8'd7},
        // R2: load 0x012 read; R5 linear 3 -> 0
        '{10'h012,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'hA2A2A2A2,8'd2},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'hA3A3A3A3,8'd5},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'hA0A0A0A0,8'd5},
        // R6: interleaved from 0x011: 1,0,3,(hold 3),2
        '{10'h011,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,32'h0,1'b1,32'hA1A1A1A1,8'd6},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,32'h0,1'b1,32'hA0A0A0A0,8'd6},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,32'h0,1'b1,32'hA3A3A3A3,8'd6},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,32'h0,1'b1,32'hA3A3A3A3,8'd7},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,32'h0,1'b1,32'hA2A2A2A2,8'd6},
        // R9: lanes 0 and 2 written at 0x012
        '{10'h012,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'b1010,1'b0,32'h11223344,1'b1,32'hA222A244,8'd9},
        // R8: whole-word write with lane controls idle
        '{10'h013,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,32'h55667788,1'b1,32'h55667788,8'd8},
        // R3: processor strobe with chip enable high ignored
        '{10'h010,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'h55667788,8'd3},
        // R3: processor strobe with chip enable low loads
        '{10'h010,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'hA0A0A0A0,8'd3},
        // R4: deselecting start, then write attempt, then readback
        '{10'h011,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,32'h0,1'b0,32'h0,8'd4},
        '{10'h012,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,32'hDEADBEEF,1'b0,32'h0,8'd4},
        '{10'h012,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'hA222A244,8'd4},
        // R13: start with advance low loads 0x011
        '{10'h011,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,32'h0,1'b1,32'hA1A1A1A1,8'd13},
        // R10: lane enable with no lane, then lanes selected without enable
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,1'b0,32'h0,1'b1,32'hA1A1A1A1,8'd10},
        '{10'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,32'h0,1'b1,32'hA1A1A1A1,8'd10}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  addr;
    logic [31:0] wdata, rdata;
    logic        proc_strobe_n, ctl_strobe_n, advance_n, chip_en_n, sel_hi, sel_n;
    logic        all_wr_n, lane_wr_n, out_en_n, sleep, order_sel, rdata_vld;
    logic [3:0]  lane_sel_n;
    int          nvec = 0;
    int          nbad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fts_sram dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .proc_strobe_n(proc_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .advance_n(advance_n), .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_n(sel_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .sleep(sleep), .order_sel(order_sel),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic check(input int req, input logic exp_en, input logic [31:0] exp_q);
        nvec++;
        if (rdata_vld !== exp_en || rdata !== exp_q) begin
            nbad++;
            $display("FAIL R%0d: vld=%0b data=%h expected vld=%0b data=%h",
                     req, rdata_vld, rdata, exp_en, exp_q);
        end
    endtask

    task automatic drive(input vec_t v);
        addr = v.a; ctl_strobe_n = v.cs_n; proc_strobe_n = v.ps_n; chip_en_n = v.ce_n;
        sel_hi = v.s_hi; sel_n = v.s_n; advance_n = v.adv_n; all_wr_n = v.aw_n;
        lane_wr_n = v.lw_n; lane_sel_n = v.ls_n; order_sel = v.ord; wdata = v.d;
    endtask

    task automatic idle();
        addr = '0; ctl_strobe_n = 1'b1; proc_strobe_n = 1'b1; chip_en_n = 1'b0;
        sel_hi = 1'b1; sel_n = 1'b0; advance_n = 1'b1; all_wr_n = 1'b1;
        lane_wr_n = 1'b1; lane_sel_n = 4'hF; order_sel = 1'b0; wdata = '0;
    endtask

    initial begin
        idle();
        out_en_n = 1'b0; sleep = 1'b0; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 check(1, 1'b0, 32'h0);            // R1 during reset
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1 check(1, 1'b0, 32'h0);  // R1 after reset

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VEC[i]);
            @(posedge clk); #1 check(int'(VEC[i].req), VEC[i].en, VEC[i].q);
        end

        // R11: output enable acts without a clock edge
        @(negedge clk) idle(); out_en_n = 1'b1;
        #1 check(11, 1'b0, 32'h0);
        out_en_n = 1'b0;
        #1 check(11, 1'b1, 32'hA1A1A1A1);

        // R12: sleep with a live load and write request
        @(negedge clk) sleep = 1'b1; addr = 10'h013; ctl_strobe_n = 1'b0;
        all_wr_n = 1'b0; wdata = 32'h0; advance_n = 1'b0;
        #1 check(12, 1'b0, 32'h0);
        @(posedge clk); #1 check(12, 1'b0, 32'h0);
        @(negedge clk) idle(); sleep = 1'b0;
        #1 check(12, 1'b1, 32'hA1A1A1A1);
        @(negedge clk) addr = 10'h013; ctl_strobe_n = 1'b0;
        @(posedge clk); #1 check(12, 1'b1, 32'h55667788);

        // R1: reset in the middle of an access
        @(negedge clk) idle(); rst = 1'b1;
        @(posedge clk); #1 check(1, 1'b0, 32'h0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1 check(1, 1'b0, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule